// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two parallel ports, A and B, through a set of independent byte-wide sections. Each section holds one storage register per direction. An edge on its A-to-B strobe captures the A port into the A-side register, and an edge on its B-to-A strobe captures the B port into the B-side register. An active-low output enable and a direction bit decide which port the section drives, if any. A per-direction source select then chooses what goes out: the live value of the opposite port or the stored register contents.

Tri-state pins are split into a pin-input vector, a pin-output vector and one output-enable bit per section and port, so the block synthesizes as plain logic. The strobes are sampled by the system clock, and a register loads at the clock edge on which its strobe is first seen high. The live paths are purely combinational and add no latency. Capture does not depend on the enable or the direction, so data can be parked in the registers while both ports are isolated.

Top module: `bus_xcvr`

## Requirements
- R1: An asynchronous active-low reset clears every storage register to zero, so stored-mode outputs read 0 after reset.
- R2: While a section's `oeN` bit is 1, that section's `aOe` and `bOe` bits are both 0.
- R3: With `oeN`=0, `dir`=0 drives port A only (`aOe`=1, `bOe`=0); with `oeN`=0, `dir`=1 drives port B only (`bOe`=1, `aOe`=0).
- R4: No section ever has its `aOe` and `bOe` bits set together.
- R5: When driving A with `selBA`=0, the section's `aOut` slice equals its `bIn` slice in the same cycle.
- R6: When driving A with `selBA`=1, the section's `aOut` slice equals its B-side register.
- R7: When driving B, `bOut` equals the live `aIn` slice when `selAB`=0 and the A-side register when `selAB`=1.
- R8: A register loads its port slice only at the clock edge where its strobe is sampled 1 after being sampled 0 at the previous edge; holding the strobe high loads nothing more.
- R9: Capture works for either register regardless of `oeN` and `dir`, including during isolation.
- R10: Sections are independent: controls and strobes of one section never change another section's registers or outputs. Section s uses bits [s*8 +: 8] of each data vector and bit s of each control vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling the strobes |
| rstN | input | 1 | Asynchronous active-low reset |
| oeN | input | 2 | Per-section output enable, active low |
| dir | input | 2 | Per-section direction: 0 drives A, 1 drives B |
| strbAB | input | 2 | Per-section strobe capturing port A |
| strbBA | input | 2 | Per-section strobe capturing port B |
| selAB | input | 2 | Source for port B: 0 live A, 1 stored A |
| selBA | input | 2 | Source for port A: 0 live B, 1 stored B |
| aIn | input | 16 | Value seen at the A pins |
| aOut | output | 16 | Value to drive onto the A pins |
| aOe | output | 2 | Per-section A pin drive enable |
| bIn | input | 16 | Value seen at the B pins |
| bOut | output | 16 | Value to drive onto the B pins |
| bOe | output | 2 | Per-section B pin drive enable |

## Verification
The hardest condition to reach is a strobe held high for several cycles while the port data keeps changing. Only the first edge may load, and the stored value can only be seen later, through a stored-mode output. A directed phase holds one strobe high across new data and then reads the register back with the select set to stored. A second directed phase loads both registers during isolation and reads them back afterwards. Random cycles with strobe bits toggled freely then cover rise, hold and fall on both sections at once, and a bench model tracks the previous strobe level for each register.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  // Per-section strobes from control to datapath
  typedef struct packed {
    logic capA;       // load A-side register this edge
    logic capB;       // load B-side register this edge
    logic driveA;     // drive port A
    logic driveB;     // drive port B
    logic useRegToA;  // port A gets stored B data
    logic useRegToB;  // port B gets stored A data
  } laneCtl_t;
endpackage

// File: rtl/bxr_ctrl.sv
module bxr_ctrl
  import bxr_pkg::*;
#(
  parameter int NUM_SECT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SECT-1:0] oeN,
  input  logic [NUM_SECT-1:0] dir,
  input  logic [NUM_SECT-1:0] strbAB,
  input  logic [NUM_SECT-1:0] strbBA,
  input  logic [NUM_SECT-1:0] selAB,
  input  logic [NUM_SECT-1:0] selBA,
  output laneCtl_t            ctl [NUM_SECT]
);
  logic [NUM_SECT-1:0] prevAB;
  logic [NUM_SECT-1:0] prevBA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevAB <= '0;
      prevBA <= '0;
    end else begin
      prevAB <= strbAB;
      prevBA <= strbBA;
    end
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    always_comb begin
      ctl[s].capA      = strbAB[s] & ~prevAB[s];
      ctl[s].capB      = strbBA[s] & ~prevBA[s];
      ctl[s].driveA    = ~oeN[s] & ~dir[s];
      ctl[s].driveB    = ~oeN[s] &  dir[s];
      ctl[s].useRegToA = selBA[s];
      ctl[s].useRegToB = selAB[s];
    end
  end
endmodule

// File: rtl/bxr_path.sv
module bxr_path
  import bxr_pkg::*;
#(
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneCtl_t          ctl,
  input  logic [SECT_W-1:0] aIn,
  input  logic [SECT_W-1:0] bIn,
  output logic [SECT_W-1:0] aOut,
  output logic              aOe,
  output logic [SECT_W-1:0] bOut,
  output logic              bOe
);
  logic [SECT_W-1:0] regA;
  logic [SECT_W-1:0] regB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (ctl.capA) regA <= aIn;
      if (ctl.capB) regB <= bIn;
    end
  end

  always_comb begin
    aOut = ctl.useRegToA ? regB : bIn;
    bOut = ctl.useRegToB ? regA : aIn;
    aOe  = ctl.driveA;
    bOe  = ctl.driveB;
  end
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bxr_pkg::*;
#(
  parameter int NUM_SECT = 2,
  parameter int SECT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SECT-1:0]        oeN,
  input  logic [NUM_SECT-1:0]        dir,
  input  logic [NUM_SECT-1:0]        strbAB,
  input  logic [NUM_SECT-1:0]        strbBA,
  input  logic [NUM_SECT-1:0]        selAB,
  input  logic [NUM_SECT-1:0]        selBA,
  input  logic [NUM_SECT*SECT_W-1:0] aIn,
  output logic [NUM_SECT*SECT_W-1:0] aOut,
  output logic [NUM_SECT-1:0]        aOe,
  input  logic [NUM_SECT*SECT_W-1:0] bIn,
  output logic [NUM_SECT*SECT_W-1:0] bOut,
  output logic [NUM_SECT-1:0]        bOe
);
  laneCtl_t ctl [NUM_SECT];

  bxr_ctrl #(.NUM_SECT(NUM_SECT)) u_ctrl (
    .clk(clk), .rstN(rstN), .oeN(oeN), .dir(dir),
    .strbAB(strbAB), .strbBA(strbBA), .selAB(selAB), .selBA(selBA),
    .ctl(ctl)
  );

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_lane
    bxr_path #(.SECT_W(SECT_W)) u_path (
      .clk(clk), .rstN(rstN), .ctl(ctl[s]),
      .aIn(aIn[s*SECT_W +: SECT_W]), .bIn(bIn[s*SECT_W +: SECT_W]),
      .aOut(aOut[s*SECT_W +: SECT_W]), .aOe(aOe[s]),
      .bOut(bOut[s*SECT_W +: SECT_W]), .bOe(bOe[s])
    );
  end
endmodule

// File: rtl/bxr_check.sv
module bxr_check #(
  parameter int NUM_SECT = 2,
  parameter int SECT_W   = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_SECT-1:0]        oeN,
  input logic [NUM_SECT-1:0]        dir,
  input logic [NUM_SECT-1:0]        selAB,
  input logic [NUM_SECT-1:0]        selBA,
  input logic [NUM_SECT*SECT_W-1:0] aIn,
  input logic [NUM_SECT*SECT_W-1:0] bIn,
  input logic [NUM_SECT*SECT_W-1:0] aOut,
  input logic [NUM_SECT*SECT_W-1:0] bOut,
  input logic [NUM_SECT-1:0]        aOe,
  input logic [NUM_SECT-1:0]        bOe
);
  AST_NO_DUAL_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    (aOe & bOe) == '0); // R4

  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    ((aOe | bOe) & oeN) == '0); // R2

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_chk
    AST_DRIVE_A: assert property (@(posedge clk) disable iff (!rstN)
      (!oeN[s] && !dir[s]) |-> aOe[s]); // R3

    AST_DRIVE_B: assert property (@(posedge clk) disable iff (!rstN)
      (!oeN[s] && dir[s]) |-> bOe[s]); // R3

    AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rstN)
      (aOe[s] && !selBA[s]) |-> aOut[s*SECT_W +: SECT_W] == bIn[s*SECT_W +: SECT_W]); // R5

    AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rstN)
      (bOe[s] && !selAB[s]) |-> bOut[s*SECT_W +: SECT_W] == aIn[s*SECT_W +: SECT_W]); // R7
  end
endmodule

bind bus_xcvr bxr_check #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) u_check (
  .clk(clk), .rstN(rstN), .oeN(oeN), .dir(dir), .selAB(selAB), .selBA(selBA),
  .aIn(aIn), .bIn(bIn), .aOut(aOut), .bOut(bOut), .aOe(aOe), .bOe(bOe)
);

// File: tb/bus_xcvr_test.sv
`timescale 1ns/1ps
module bus_xcvr_test;
  localparam int NS = 2;
  localparam int W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NS-1:0] oeN = '1, dir = '0, strbAB = '0, strbBA = '0, selAB = '0, selBA = '0;
  logic [NS*W-1:0] aIn = '0, bIn = '0;
  logic [NS*W-1:0] aOut, bOut;
  logic [NS-1:0] aOe, bOe;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string ctxTag = "R1";

  logic [W-1:0] mRegA [NS];
  logic [W-1:0] mRegB [NS];
  logic [NS-1:0] mPrevAB, mPrevBA;

  always #4 clk = ~clk;

  bus_xcvr #(.NUM_SECT(NS), .SECT_W(W)) uut (
    .clk(clk), .rstN(rstN), .oeN(oeN), .dir(dir), .strbAB(strbAB), .strbBA(strbBA),
    .selAB(selAB), .selBA(selBA), .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  function automatic logic [W-1:0] expA(int s);
    return selBA[s] ? mRegB[s] : bIn[s*W +: W];
  endfunction
  function automatic logic [W-1:0] expB(int s);
    return selAB[s] ? mRegA[s] : aIn[s*W +: W];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) actual=%0h expected=%0h", tag, ctxTag, act, exp);
    end
  endtask

  task automatic checkOutputs();
    for (int s = 0; s < NS; s++) begin
      logic eA, eB;
      eA = !oeN[s] && !dir[s];
      eB = !oeN[s] && dir[s];
      chk(oeN[s] ? "R2" : "R3", {30'd0, aOe[s], bOe[s]}, {30'd0, eA, eB});
      chk("R4", {31'd0, aOe[s] & bOe[s]}, 32'd0);
      if (eA) chk(selBA[s] ? "R6" : "R5", {24'd0, aOut[s*W +: W]}, {24'd0, expA(s)});
      if (eB) chk("R7", {24'd0, bOut[s*W +: W]}, {24'd0, expB(s)});
    end
  endtask

  task automatic stepEdge();
    @(posedge clk);
    for (int s = 0; s < NS; s++) begin
      if (strbAB[s] && !mPrevAB[s]) mRegA[s] = aIn[s*W +: W];
      if (strbBA[s] && !mPrevBA[s]) mRegB[s] = bIn[s*W +: W];
    end
    mPrevAB = strbAB;
    mPrevBA = strbBA;
    @(negedge clk);
  endtask

  task automatic cycle(logic [NS-1:0] o, logic [NS-1:0] d, logic [NS-1:0] sa, logic [NS-1:0] sb,
                       logic [NS-1:0] pa, logic [NS-1:0] pb, logic [NS*W-1:0] a, logic [NS*W-1:0] b);
    oeN = o; dir = d; strbAB = sa; strbBA = sb; selAB = pa; selBA = pb; aIn = a; bIn = b;
    #1;
    checkOutputs();
    stepEdge();
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin mRegA[s] = '0; mRegB[s] = '0; end
    mPrevAB = '0; mPrevBA = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: stored mode right after reset reads zero
    ctxTag = "R1";
    cycle('0, '0, '0, '0, '1, '1, 16'hA5C3, 16'h3C5A);
    cycle('0, '1, '0, '0, '1, '1, 16'h1234, 16'h5678);

    // R8: hold strobe high while data changes; only first edge loads
    ctxTag = "R8";
    cycle('1, '0, 2'b01, '0, '0, '0, 16'h0011, 16'h0);
    cycle('1, '0, 2'b01, '0, '0, '0, 16'h0022, 16'h0);
    cycle('1, '0, 2'b01, '0, '0, '0, 16'h0033, 16'h0);
    cycle('0, '1, '0, '0, '1, '0, 16'h0044, 16'h0);

    // R9: capture both registers while isolated, read back later
    ctxTag = "R9";
    cycle('1, 2'b10, '1, '1, '0, '0, 16'hBEEF, 16'hCAFE);
    cycle('0, '0, '0, '0, '1, '1, 16'h0, 16'h0);
    cycle('0, '1, '0, '0, '1, '1, 16'h0, 16'h0);

    // R10: strobe section 1 only, section 0 stored values unchanged
    ctxTag = "R10";
    cycle('1, '0, 2'b10, 2'b10, '0, '0, 16'h7788, 16'h99AA);
    cycle(2'b00, 2'b01, '0, '0, '1, '1, 16'h0, 16'h0);
    cycle(2'b00, 2'b10, '0, '0, '1, '1, 16'h0, 16'h0);

    // Random mix
    ctxTag = "rand";
    for (int i = 0; i < 2000; i++) begin
      cycle($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule